// File: doc/BRIEF.md
# Panel reset and init sequencer

This block brings an LCD panel from power-up to a running display with no processor involvement. A single start pulse sets off the whole flow. First it drives the panel's active-low reset pin through a timed high/low/high pattern. It then reads the panel's identification byte through an attached serial command engine. That byte picks one of two built-in initialization scripts, which the block replays entry by entry. It finishes by switching the display on and, after a pause, taking the panel out of sleep.

Each script entry has three parts: a command byte, a parameter list of 0 to 21 bytes, and an optional wait in milliseconds once its last byte has gone out. All waits are whole milliseconds. A prescaler divides the system clock down to a millisecond tick, and `CLK_PER_MS` sets how many clock cycles make one millisecond. The serial engine does the bit shifting. It sees one word per request, uses a level request with a one-cycle acknowledge, and reports errors on that acknowledge. The block records any error in a sticky flag and carries on with the sequence.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, and until `start` is seen, `panel_rst_n` is 0 and `req`, `req_rd`, `done`, `err` and `script_sel` are all 0.
- R2: `start` drives `panel_rst_n` high for 100 ms, low for 40 ms and then high again, where it stays. No request is made until 100 ms after the second rising edge.
- R3: The first request is a read: `req_rd`=1 with word 0x004. The byte 0x80 returned without error sets `script_sel`=0, the short script. Any other byte, or an acknowledge with `ack_err`, sets `script_sel`=1, the long script. `script_sel` does not change again until reset.
- R4: `req_word[8]` is 0 for a command byte and 1 for a parameter byte, and `req_word[7:0]` holds the byte. Each entry sends its command and then its parameters in list order. A request stays high with its word unchanged until the cycle it is acknowledged.
- R5: The short script has 8 entries. It opens with 0x36 {0x08} and 0x3A {0x66}, and its two 16-byte gamma entries are 0xE0 and 0xE1. Entry 0xE1 is followed by a 20 ms wait. The last entry, 0xB4 {0x02}, is followed by a 100 ms wait. No other entry waits.
- R6: The long script has 22 entries and no waits. It opens with 0xFF {0xFF, 0x98, 0x06}. Its 0xBC entry carries 21 parameters.
- R7: For an entry with a wait of d ms, `req` is low for exactly d·`CLK_PER_MS` cycles after its last acknowledge. For a zero wait, the next word is requested in the cycle right after the acknowledge.
- R8: After the script the block sends command 0x29 alone, keeps `req` low for 100 ms, and then sends command 0x11 alone.
- R9: `done` rises in the cycle after the 0x11 word is acknowledged. It then holds, with no further requests, until reset.
- R10: `err` becomes 1 when an acknowledge carries `ack_err` and stays 1 until reset. The word sequence is unaffected.
- R11: `start` has no effect while a sequence is running or after `done`.
- R12: One millisecond is exactly `CLK_PER_MS` clock cycles for every wait and reset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the power-up flow when idle |
| panel_rst_n | output | 1 | Active-low reset pin of the panel |
| req | output | 1 | Serial word request, held until acknowledged |
| req_rd | output | 1 | Request is the identification read |
| req_word | output | 9 | Bit 8: 1 = parameter, 0 = command; bits 7:0 the byte |
| ack | input | 1 | One-cycle completion of the current request |
| ack_err | input | 1 | Serial error or timeout, valid with `ack` |
| ack_data | input | 8 | Byte read back, valid with `ack` on a read |
| done | output | 1 | Sleep-out completed; holds until reset |
| err | output | 1 | Sticky serial error flag |
| script_sel | output | 1 | Script in use: 0 short, 1 long |

## Verification
The in-line assertions watch the handshake and state rules on every cycle. A request must hold its word until it is acknowledged, and no request may appear while the panel is held in reset. The error and done flags must stay set once raised, the script choice must stay frozen once words are flowing, and the prescaler must stay in range. Other properties only show up in whole scenarios: the exact length of each reset phase and each wait, which script a given identification byte selects, the order and content of every word in both scripts, and whether a stray start is ignored. The bench covers these by running matching and non-matching IDs, an error on the ID read, and an error in the middle of the script.

// File: rtl/panel_init_seq.sv
module panel_init_seq #(
  parameter int CLK_PER_MS = 50000,
  parameter int MS_W = 8,
  parameter int RST_HI_MS = 100,
  parameter int RST_LO_MS = 40,
  parameter int RST_SETTLE_MS = 100,
  parameter int DISP_GAP_MS = 100,
  parameter logic [7:0] ID_CMD = 8'h04,
  parameter logic [7:0] ID_SHORT = 8'h80,
  parameter logic [7:0] DISP_ON = 8'h29,
  parameter logic [7:0] SLEEP_OUT = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       panel_rst_n,
  output logic       req,
  output logic       req_rd,
  output logic [8:0] req_word,
  input  logic       ack,
  input  logic       ack_err,
  input  logic [7:0] ack_data,
  output logic       done,
  output logic       err,
  output logic       script_sel
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int ENT_W = 5;
  localparam int CNT_W = 5;
  localparam int DLY_W = 7;
  localparam int MAXP  = 21;
  localparam int PAR_W = 8 * MAXP;
  localparam int ROM_W = 8 + CNT_W + DLY_W + PAR_W;
  localparam logic [ENT_W-1:0] LAST_SHORT = 5'd7;
  localparam logic [ENT_W-1:0] LAST_LONG  = 5'd21;

  typedef enum logic [3:0] {
    S_IDLE, S_RHI, S_RLO, S_RSET, S_ID, S_SEND, S_POST, S_DON, S_GAP, S_SOUT, S_DONE
  } st_t;

  st_t st;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms_left;
  logic [ENT_W-1:0] ent;
  logic [CNT_W-1:0] widx;
  logic [7:0]       cur_cmd;
  logic [CNT_W-1:0] cur_cnt;
  logic [DLY_W-1:0] cur_dly;
  logic [PAR_W-1:0] cur_par;
  logic             waiting, tick, expire, last_ent;

  // Entry record: {command, parameter count, post-wait ms, parameters (first byte most significant)}
  function automatic logic [ROM_W-1:0] script_rom(input logic sel, input logic [ENT_W-1:0] e);
    logic [7:0]       c;
    logic [CNT_W-1:0] n;
    logic [DLY_W-1:0] d;
    logic [PAR_W-1:0] p;
    c = 8'h00; n = '0; d = '0; p = '0;
    if (!sel) begin
      case (e)
        5'd0: begin c = 8'h36; n = 5'd1;  p = 168'h08; end
        5'd1: begin c = 8'h3A; n = 5'd1;  p = 168'h66; end
        5'd2: begin c = 8'hB6; n = 5'd4;  p = 168'h22E2FF04; end
        5'd3: begin c = 8'hC5; n = 5'd2;  p = 168'h006A; end
        5'd4: begin c = 8'hE0; n = 5'd16; p = 168'h00070D1013190F0C050806130F30201F; end
        5'd5: begin c = 8'hE1; n = 5'd16; d = 7'd20;  p = 168'h1F20300F130608050C0F1913100D0700; end
        5'd6: begin c = 8'hB0; n = 5'd1;  p = 168'h01; end
        5'd7: begin c = 8'hB4; n = 5'd1;  d = 7'd100; p = 168'h02; end
        default: ;
      endcase
    end else begin
      case (e)
        5'd0:  begin c = 8'hFF; n = 5'd3;  p = 168'hFF9806; end
        5'd1:  begin c = 8'hBA; n = 5'd1;  p = 168'h60; end
        5'd2:  begin c = 8'hBC; n = 5'd21; p = 168'h0110617401011B127100000001010500FFF2010040; end
        5'd3:  begin c = 8'hBD; n = 5'd8;  p = 168'h0123456701234567; end
        5'd4:  begin c = 8'hBE; n = 5'd9;  p = 168'h012222BADC26282222; end
        5'd5:  begin c = 8'hC7; n = 5'd1;  p = 168'h74; end
        5'd6:  begin c = 8'hED; n = 5'd3;  p = 168'h7F0F00; end
        5'd7:  begin c = 8'hC0; n = 5'd3;  p = 168'h030B00; end
        5'd8:  begin c = 8'hFC; n = 5'd1;  p = 168'h08; end
        5'd9:  begin c = 8'hB6; n = 5'd1;  p = 168'hA0; end
        5'd10: begin c = 8'hDF; n = 5'd6;  p = 168'h000000000020; end
        5'd11: begin c = 8'hF3; n = 5'd1;  p = 168'h74; end
        5'd12: begin c = 8'hB4; n = 5'd3;  p = 168'h000000; end
        5'd13: begin c = 8'hF7; n = 5'd1;  p = 168'h82; end
        5'd14: begin c = 8'hB1; n = 5'd3;  p = 168'h001313; end
        5'd15: begin c = 8'hF2; n = 5'd4;  p = 168'h80054028; end
        5'd16: begin c = 8'hC1; n = 5'd4;  p = 168'h17757920; end
        5'd17: begin c = 8'h36; n = 5'd1;  p = 168'h00; end
        5'd18: begin c = 8'h3A; n = 5'd1;  p = 168'h66; end
        5'd19: begin c = 8'hE0; n = 5'd16; p = 168'h00030B0C0E08C504080C131111140C10; end
        5'd20: begin c = 8'hE1; n = 5'd16; p = 168'h000D110C0C047603080B16100D160A00; end
        5'd21: begin c = 8'h35; n = 5'd1;  p = 168'h00; end
        default: ;
      endcase
    end
    return {c, n, d, p};
  endfunction

  assign {cur_cmd, cur_cnt, cur_dly, cur_par} = script_rom(script_sel, ent);
  assign last_ent = (ent == (script_sel ? LAST_LONG : LAST_SHORT));

  assign waiting = (st == S_RHI) || (st == S_RLO) || (st == S_RSET) || (st == S_POST) || (st == S_GAP);
  assign tick    = waiting && (pre == PRE_W'(CLK_PER_MS - 1));
  assign expire  = tick && (ms_left == MS_W'(1));

  assign req         = (st == S_ID) || (st == S_SEND) || (st == S_DON) || (st == S_SOUT);
  assign req_rd      = (st == S_ID);
  assign done        = (st == S_DONE);
  assign panel_rst_n = (st != S_IDLE) && (st != S_RLO);

  always_comb begin
    case (st)
      S_ID:    req_word = {1'b0, ID_CMD};
      S_SEND:  req_word = (widx == '0) ? {1'b0, cur_cmd}
                                       : {1'b1, cur_par[{cur_cnt - widx, 3'b000} +: 8]};
      S_DON:   req_word = {1'b0, DISP_ON};
      S_SOUT:  req_word = {1'b0, SLEEP_OUT};
      default: req_word = 9'h000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pre        <= '0;
      ms_left    <= '0;
      ent        <= '0;
      widx       <= '0;
      err        <= 1'b0;
      script_sel <= 1'b0;
    end else begin
      pre <= (waiting && !tick) ? pre + 1'b1 : '0;
      if (tick) ms_left <= ms_left - 1'b1;
      if (req && ack && ack_err) err <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RHI;
          ms_left <= MS_W'(RST_HI_MS);
        end
        S_RHI: if (expire) begin
          st <= S_RLO;
          ms_left <= MS_W'(RST_LO_MS);
        end
        S_RLO: if (expire) begin
          st <= S_RSET;
          ms_left <= MS_W'(RST_SETTLE_MS);
        end
        S_RSET: if (expire) st <= S_ID;
        S_ID: if (ack) begin
          script_sel <= ack_err || (ack_data != ID_SHORT);
          ent  <= '0;
          widx <= '0;
          st   <= S_SEND;
        end
        S_SEND: if (ack) begin
          if (widx != cur_cnt) widx <= widx + 1'b1;
          else begin
            widx <= '0;
            if (cur_dly != '0) begin
              st <= S_POST;
              ms_left <= MS_W'(cur_dly);
            end else if (last_ent) st <= S_DON;
            else ent <= ent + 1'b1;
          end
        end
        S_POST: if (expire) begin
          if (last_ent) st <= S_DON;
          else begin
            ent <= ent + 1'b1;
            st  <= S_SEND;
          end
        end
        S_DON: if (ack) begin
          st <= S_GAP;
          ms_left <= MS_W'(DISP_GAP_MS);
        end
        S_GAP:  if (expire) st <= S_SOUT;
        S_SOUT: if (ack) st <= S_DONE;
        default: ;
      endcase
    end
  end

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(req_word) && $stable(req_rd)));

  // R2
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !req);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !req));

  // R3
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_rd) |=> $stable(script_sel));

  // R12
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_W'(CLK_PER_MS - 1));
endmodule

// File: tb/sim_panel_init_seq.sv
module sim_panel_init_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int P = 4;
  localparam int LAT = 2;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, start, ack, ack_err;
  logic [7:0] ack_data;
  logic       panel_rst_n, req, req_rd, done, err, script_sel;
  logic [8:0] req_word;

  panel_init_seq #(.CLK_PER_MS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .panel_rst_n(panel_rst_n),
    .req(req), .req_rd(req_rd), .req_word(req_word), .ack(ack),
    .ack_err(ack_err), .ack_data(ack_data), .done(done), .err(err),
    .script_sel(script_sel));

  int checks = 0;
  int fails = 0;

  typedef struct { logic [8:0] w; logic rd; int gap; int rq; } txn_t;
  txn_t q[$];
  txn_t cur;
  int pend, cyc, gap, cnt_dn, tix, err_at, tail;
  bit in_txn, m_done, m_err, m_sel, cur_bad;
  logic [7:0] id_val;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(logic [8:0] w, logic rd, int g, int rq);
    txn_t t;
    t.w = w; t.rd = rd; t.gap = g; t.rq = rq;
    q.push_back(t);
  endfunction

  function automatic void ent(logic [7:0] c, int n, int d, logic [167:0] v, int rq);
    push({1'b0, c}, 1'b0, pend, rq);
    pend = 0;
    for (int i = 0; i < n; i++) push({1'b1, v[8*(n-1-i) +: 8]}, 1'b0, 0, rq);
    pend = d * P;
  endfunction

  task automatic build(input bit sel);
    q.delete();
    push(9'h004, 1'b1, 240 * P, 3);   // R3 ID read after R2 reset pattern
    pend = 0;
    if (!sel) begin                    // R5 short script
      ent(8'h36, 1, 0, 168'h08, 5);
      ent(8'h3A, 1, 0, 168'h66, 5);
      ent(8'hB6, 4, 0, 168'h22E2FF04, 5);
      ent(8'hC5, 2, 0, 168'h006A, 5);
      ent(8'hE0, 16, 0, 168'h00070D1013190F0C050806130F30201F, 5);
      ent(8'hE1, 16, 20, 168'h1F20300F130608050C0F1913100D0700, 5);
      ent(8'hB0, 1, 0, 168'h01, 5);
      ent(8'hB4, 1, 100, 168'h02, 5);
    end else begin                     // R6 long script
      ent(8'hFF, 3, 0, 168'hFF9806, 6);
      ent(8'hBA, 1, 0, 168'h60, 6);
      ent(8'hBC, 21, 0, 168'h0110617401011B127100000001010500FFF2010040, 6);
      ent(8'hBD, 8, 0, 168'h0123456701234567, 6);
      ent(8'hBE, 9, 0, 168'h012222BADC26282222, 6);
      ent(8'hC7, 1, 0, 168'h74, 6);
      ent(8'hED, 3, 0, 168'h7F0F00, 6);
      ent(8'hC0, 3, 0, 168'h030B00, 6);
      ent(8'hFC, 1, 0, 168'h08, 6);
      ent(8'hB6, 1, 0, 168'hA0, 6);
      ent(8'hDF, 6, 0, 168'h000000000020, 6);
      ent(8'hF3, 1, 0, 168'h74, 6);
      ent(8'hB4, 3, 0, 168'h000000, 6);
      ent(8'hF7, 1, 0, 168'h82, 6);
      ent(8'hB1, 3, 0, 168'h001313, 6);
      ent(8'hF2, 4, 0, 168'h80054028, 6);
      ent(8'hC1, 4, 0, 168'h17757920, 6);
      ent(8'h36, 1, 0, 168'h00, 6);
      ent(8'h3A, 1, 0, 168'h66, 6);
      ent(8'hE0, 16, 0, 168'h00030B0C0E08C504080C131111140C10, 6);
      ent(8'hE1, 16, 0, 168'h000D110C0C047603080B16100D160A00, 6);
      ent(8'h35, 1, 0, 168'h00, 6);
    end
    push(9'h029, 1'b0, pend, 8);       // R8 display on, then 100 ms, then sleep out
    push(9'h011, 1'b0, 100 * P, 8);
  endtask

  task automatic step();
    bit exp_pin;
    cyc++;
    start = (cyc == 50) || (tail == 3);  // R11 stray start pulses
    if (ack) begin
      ack = 1'b0;
      ack_err = 1'b0;
      in_txn = 1'b0;
      if (cur_bad) m_err = 1'b1;
      if (cur.rd) m_sel = cur_bad || (id_val != 8'h80);
      if (q.size() == 0) m_done = 1'b1;
      cur_bad = 1'b0;
    end
    exp_pin = !(cyc > 100 * P && cyc <= 140 * P);
    chk(panel_rst_n == exp_pin, "R2", "panel reset pin level", panel_rst_n, exp_pin);
    chk(done == m_done, "R9", "done flag", done, m_done);
    chk(err == m_err, "R10", "sticky error", err, m_err);
    chk(script_sel == m_sel, "R3", "script select", script_sel, m_sel);
    if (!in_txn) begin
      if (req) begin
        if (q.size() == 0) chk(1'b0, "R9", "request after sleep-out", req_word, 0);
        else begin
          cur = q.pop_front();
          tix++;
          chk(req_word == cur.w, $sformatf("R%0d", cur.rq), "request word", req_word, cur.w);
          chk(req_rd == cur.rd, "R3", "read flag", req_rd, cur.rd);
          chk(gap == cur.gap, (tix == 1) ? "R12" : "R7", "idle cycles before request", gap, cur.gap);
          in_txn = 1'b1;
          cnt_dn = LAT;
          gap = 0;
        end
      end else gap++;
    end else begin
      chk(req && req_word == cur.w && req_rd == cur.rd, "R4", "request held until ack", req_word, cur.w);
    end
    if (in_txn) begin
      if (cnt_dn == 0) begin
        ack = 1'b1;
        cur_bad = (tix == err_at);
        ack_err = cur_bad;
        ack_data = cur.rd ? id_val : 8'hA5;
      end else cnt_dn--;
    end
  endtask

  task automatic run(input logic [7:0] id, input int eidx);
    rst_n = 1'b0; start = 1'b0; ack = 1'b0; ack_err = 1'b0; ack_data = 8'h00;
    cyc = 0; gap = 0; tix = 0; tail = 0; in_txn = 0; cur_bad = 0;
    m_done = 0; m_err = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      // R1 idle state before start
      chk(!panel_rst_n && !req && !req_rd && !done && !err && !script_sel, "R1", "idle outputs",
          {panel_rst_n, req, req_rd, done, err, script_sel}, 0);
    end
    id_val = id;
    err_at = eidx;
    build((eidx == 1) || (id != 8'h80));
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    step();
    while (!(m_done && tail >= 12) && cyc < LIMIT) begin
      @(negedge clk);
      step();
      if (m_done) tail++;
    end
    if (cyc >= LIMIT) chk(1'b0, "R9", "sequence did not complete", q.size(), 0);
    chk(q.size() == 0, "R9", "all words issued", q.size(), 0);
    chk(done && !req, "R11", "done unaffected by late start", {done, req}, 2'b10);
  endtask

  initial begin
    run(8'h80, 0);    // short script, clean
    run(8'h81, 10);   // long script, error inside a parameter run
    run(8'h80, 1);    // error on ID read forces long script
    run(8'h00, 0);    // other ID, long script, clean
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run hung act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule